// File: doc/BRIEF.md
# Multi-cycle microcode sequencer

This block is the control sequencer of a small 16-bit CPU. It holds a micro-program counter that walks a 64-word microcode store, built inside the block as a computed constant table. Each of the 32 opcodes has its own entry word in the lower half of the store. Instructions that need more than one step jump into the upper half and continue there. Every micro-op can pick one of two successor addresses, based on a selectable condition. One of those conditions is the memory acknowledge, so a memory access waits by branching back to its own address until the memory answers.

Each micro-op word also carries an end-of-instruction bit. When that bit is set, the current micro-op is the last step of its instruction, and the sequencer decides what runs next. Four cases apply, in priority order. A stall request sends it to an idle word. A pending interrupt sends it to an interrupt routine. A pending skip makes it drop the fetched opcode. Otherwise it loads the fetched opcode as the next address and raises a strobe in the first cycle of the new instruction. Stall and skip have no effect in the middle of an instruction: a stall is sampled only at the boundary, and a skip is remembered until the boundary.

Top module: `ucode_seq`

## Requirements
- R1: While reset is active, and in the first cycle after it, `uaddr` is 0, `new_instr` is 1 and `ctrl` is 0.
- R2: `ctrl` is {kind[1:0], uaddr}. The kind is 00 for an entry word (0–31), 01 for a continuation or completion word (32–39, 50, 51, 55), 10 for a memory wait word (40–47) and 11 for an interrupt word (48, 49). Unused words, including idle word 63, give `ctrl` = 0.
- R3: At a boundary with no stall, no interrupt and no skip, the next `uaddr` equals `opcode`. `new_instr` is 1 exactly in the cycles where `uaddr` holds a freshly loaded opcode entry.
- R4: Opcodes 0–7 take one step. Opcodes 8–15 take two: the entry word, then word 32+(opcode−8).
- R5: Opcodes 16–23 go from the entry word to wait word 40+(opcode−16). That word repeats while `mem_ack` is 0 and moves to word 55 in the cycle after `mem_ack` is 1. Word 55 ends the instruction.
- R6: Opcodes 24–27 branch on `flags[0]` and opcodes 28–31 branch on `flags[1]`. If the flag is 1 the next word is 50; if it is 0 the next word is 51. Both words end the instruction.
- R7: `stall` has no effect in the middle of an instruction. At a boundary it sends the sequencer to idle word 63, which is itself a boundary, and holds it there with `new_instr` low for as long as `stall` stays high.
- R8: A `skip` pulse seen at any cycle is held until the next boundary that is not taken by stall or interrupt. At that boundary the fetched opcode is dropped: the sequencer goes to word 63 with `new_instr` low, and the following boundary loads the opcode again.
- R9: At a boundary with `irq` high and no stall, the sequencer runs the interrupt routine, words 48 then 49, instead of loading the opcode.
- R10: At a boundary the priority is stall, then interrupt, then skip, then opcode load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 5 | Fetched opcode |
| mem_ack | input | 1 | Memory acknowledge condition |
| flags | input | 2 | General condition flags |
| stall | input | 1 | Stall request, sampled at boundaries |
| skip | input | 1 | Request to skip the next instruction |
| irq | input | 1 | Interrupt line |
| uaddr | output | 6 | Current micro-address |
| ctrl | output | 8 | Control word of the current micro-op |
| new_instr | output | 1 | High in the first cycle of a newly loaded instruction |

## Verification
The assertions treat every input as synchronous to `clk`, stable around the rising edge, and free of unknown values after reset. They also rely on every instruction reaching a boundary: an access that waits on `mem_ack` must eventually see it rise. The bench meets these conditions by changing inputs only on the falling edge. It drives `mem_ack` high after a few wait cycles, and it drops `irq`, `stall` and `skip` as soon as the scenario under test has consumed them.

// File: rtl/ucode_seq.sv
module ucode_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] opcode,
  input  logic       mem_ack,
  input  logic [1:0] flags,
  input  logic       stall,
  input  logic       skip,
  input  logic       irq,
  output logic [5:0] uaddr,
  output logic [7:0] ctrl,
  output logic       new_instr
);
  localparam int AW = 6;
  localparam int CW = AW + 2;
  localparam int WW = 1 + 2 + AW + AW + CW;
  localparam logic [AW-1:0] IRQ_ENTRY = 6'd48;
  localparam logic [AW-1:0] IDLE = 6'd63;
  localparam logic [AW-1:0] MEM_DONE = 6'd55;
  localparam logic [AW-1:0] BR_TRUE = 6'd50;
  localparam logic [AW-1:0] BR_FALSE = 6'd51;

  function automatic logic [WW-1:0] rom(input logic [AW-1:0] a);
    logic eoi, live;
    logic [1:0] sel, kind;
    logic [AW-1:0] nt, nf;
    eoi = 1'b1; live = 1'b0; sel = 2'd0; kind = 2'd0; nt = IDLE; nf = IDLE;
    if (a < 6'd8) begin
      live = 1'b1;
    end else if (a < 6'd16) begin
      live = 1'b1; eoi = 1'b0; nt = 6'd32 + (a - 6'd8);
    end else if (a < 6'd24) begin
      live = 1'b1; eoi = 1'b0; nt = 6'd40 + (a - 6'd16);
    end else if (a < 6'd32) begin
      live = 1'b1; eoi = 1'b0; sel = a[2] ? 2'd3 : 2'd2; nt = BR_TRUE; nf = BR_FALSE;
    end else if (a < 6'd40) begin
      live = 1'b1; kind = 2'd1;
    end else if (a < 6'd48) begin
      live = 1'b1; kind = 2'd2; eoi = 1'b0; sel = 2'd1; nt = MEM_DONE; nf = a;
    end else if (a == IRQ_ENTRY) begin
      live = 1'b1; kind = 2'd3; eoi = 1'b0; nt = IRQ_ENTRY + 6'd1;
    end else if (a == IRQ_ENTRY + 6'd1) begin
      live = 1'b1; kind = 2'd3;
    end else if (a == BR_TRUE || a == BR_FALSE || a == MEM_DONE) begin
      live = 1'b1; kind = 2'd1;
    end
    return {eoi, sel, nt, nf, (live ? {kind, a} : {CW{1'b0}})};
  endfunction

  logic [WW-1:0] word;
  logic          w_eoi;
  logic [1:0]    w_sel;
  logic [AW-1:0] w_nt, w_nf;
  logic          cond;
  logic          skip_pend;
  logic          take_skip, load_op;
  logic [AW-1:0] nxt;

  assign word = rom(uaddr);
  assign {w_eoi, w_sel, w_nt, w_nf, ctrl} = word;

  always_comb begin
    case (w_sel)
      2'd0: cond = 1'b1;
      2'd1: cond = mem_ack;
      2'd2: cond = flags[0];
      default: cond = flags[1];
    endcase
  end

  assign take_skip = w_eoi && !stall && !irq && (skip || skip_pend);
  assign load_op = w_eoi && !stall && !irq && !skip && !skip_pend;

  always_comb begin
    if (!w_eoi)      nxt = cond ? w_nt : w_nf;
    else if (stall)  nxt = IDLE;
    else if (irq)    nxt = IRQ_ENTRY;
    else if (take_skip) nxt = IDLE;
    else             nxt = {1'b0, opcode};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uaddr <= '0;
      new_instr <= 1'b1;
      skip_pend <= 1'b0;
    end else begin
      uaddr <= nxt;
      new_instr <= load_op;
      skip_pend <= take_skip ? 1'b0 : (skip_pend || skip);
    end
  end

  AST_MIDOP_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !w_eoi |=> !new_instr); // R3
  AST_STROBE_AT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    new_instr |-> (uaddr[AW-1] == 1'b0)); // R3
  AST_OPCODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (w_eoi && !stall && !irq && !skip && !skip_pend) |=> (new_instr && uaddr == {1'b0, $past(opcode)})); // R3
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[CW-1:CW-2] == 2'd2 && !mem_ack) |=> $stable(uaddr)); // R5
  AST_STALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (w_eoi && stall) |=> (uaddr == IDLE && !new_instr)); // R7
  AST_SKIP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (w_eoi && !stall && !irq && skip) |=> (uaddr == IDLE && !new_instr)); // R8
  AST_IRQ_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    (w_eoi && !stall && irq) |=> (uaddr == IRQ_ENTRY && !new_instr)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (uaddr == IDLE) |-> (ctrl == '0)); // R2
endmodule

// File: tb/ucode_seq_test.sv
module ucode_seq_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] opcode = '0;
  logic mem_ack = 1'b0;
  logic [1:0] flags = '0;
  logic stall = 1'b0, skip = 1'b0, irq = 1'b0;
  logic [5:0] uaddr;
  logic [7:0] ctrl;
  logic new_instr;
  int total = 0, bad = 0;
  bit done = 1'b0;

  ucode_seq uut (.clk(clk), .rst_n(rst_n), .opcode(opcode), .mem_ack(mem_ack),
    .flags(flags), .stall(stall), .skip(skip), .irq(irq),
    .uaddr(uaddr), .ctrl(ctrl), .new_instr(new_instr));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [5:0] ua, input logic [7:0] cw, input logic st);
    total += 3;
    if (uaddr !== ua) begin bad++; $display("FAIL %s uaddr act=%0d exp=%0d", tag, uaddr, ua); end
    if (ctrl !== cw) begin bad++; $display("FAIL %s ctrl act=%h exp=%h", tag, ctrl, cw); end
    if (new_instr !== st) begin bad++; $display("FAIL %s new_instr act=%0b exp=%0b", tag, new_instr, st); end
  endtask

  function automatic logic [7:0] cw(input logic [1:0] k, input logic [5:0] a);
    return {k, a};
  endfunction

  task automatic t_reset();
    #(CLK_PERIOD*2);
    chk("R1 in reset", 6'd0, 8'h00, 1'b1);
    @(negedge clk); rst_n = 1'b1; opcode = 5'd0;
    chk("R1 after reset", 6'd0, 8'h00, 1'b1);
  endtask

  task automatic t_single();
    opcode = 5'd3;
    @(negedge clk); chk("R3 R4 single entry", 6'd3, cw(2'd0, 6'd3), 1'b1);
    opcode = 5'd7;
    @(negedge clk); chk("R3 back to back", 6'd7, cw(2'd0, 6'd7), 1'b1);
  endtask

  task automatic t_two_step();
    opcode = 5'd10;
    @(negedge clk); chk("R4 entry", 6'd10, cw(2'd0, 6'd10), 1'b1);
    stall = 1'b1;
    @(negedge clk); chk("R4 R7 continuation despite stall", 6'd34, cw(2'd1, 6'd34), 1'b0);
    @(negedge clk); chk("R7 stall at boundary", 6'd63, 8'h00, 1'b0);
    @(negedge clk); chk("R7 stall held", 6'd63, 8'h00, 1'b0);
    stall = 1'b0; opcode = 5'd15;
    @(negedge clk); chk("R7 release", 6'd15, cw(2'd0, 6'd15), 1'b1);
    @(negedge clk); chk("R4 last continuation", 6'd39, cw(2'd1, 6'd39), 1'b0);
  endtask

  task automatic t_mem();
    opcode = 5'd18; mem_ack = 1'b0;
    @(negedge clk); chk("R5 entry", 6'd18, cw(2'd0, 6'd18), 1'b1);
    @(negedge clk); chk("R5 wait", 6'd42, cw(2'd2, 6'd42), 1'b0);
    @(negedge clk); chk("R5 wait loop 1", 6'd42, cw(2'd2, 6'd42), 1'b0);
    @(negedge clk); chk("R5 wait loop 2", 6'd42, cw(2'd2, 6'd42), 1'b0);
    mem_ack = 1'b1;
    @(negedge clk); chk("R5 done", 6'd55, cw(2'd1, 6'd55), 1'b0);
    opcode = 5'd16; mem_ack = 1'b1;
    @(negedge clk); chk("R5 entry 16", 6'd16, cw(2'd0, 6'd16), 1'b1);
    @(negedge clk); chk("R5 wait 40", 6'd40, cw(2'd2, 6'd40), 1'b0);
    @(negedge clk); chk("R5 immediate ack", 6'd55, cw(2'd1, 6'd55), 1'b0);
    mem_ack = 1'b0;
  endtask

  task automatic t_branch();
    opcode = 5'd25; flags = 2'b01;
    @(negedge clk); chk("R6 entry 25", 6'd25, cw(2'd0, 6'd25), 1'b1);
    @(negedge clk); chk("R6 flag0 true", 6'd50, cw(2'd1, 6'd50), 1'b0);
    opcode = 5'd26; flags = 2'b10;
    @(negedge clk); chk("R6 entry 26", 6'd26, cw(2'd0, 6'd26), 1'b1);
    @(negedge clk); chk("R6 flag0 false", 6'd51, cw(2'd1, 6'd51), 1'b0);
    opcode = 5'd29; flags = 2'b10;
    @(negedge clk); chk("R6 entry 29", 6'd29, cw(2'd0, 6'd29), 1'b1);
    @(negedge clk); chk("R6 flag1 true", 6'd50, cw(2'd1, 6'd50), 1'b0);
    opcode = 5'd31; flags = 2'b01;
    @(negedge clk); chk("R6 entry 31", 6'd31, cw(2'd0, 6'd31), 1'b1);
    @(negedge clk); chk("R6 flag1 false", 6'd51, cw(2'd1, 6'd51), 1'b0);
    flags = 2'b00;
  endtask

  task automatic t_skip();
    opcode = 5'd10;
    @(negedge clk); chk("R8 entry", 6'd10, cw(2'd0, 6'd10), 1'b1);
    skip = 1'b1;
    @(negedge clk); chk("R8 mid-op skip ignored", 6'd34, cw(2'd1, 6'd34), 1'b0);
    skip = 1'b0; opcode = 5'd5;
    @(negedge clk); chk("R8 opcode dropped", 6'd63, 8'h00, 1'b0);
    @(negedge clk); chk("R8 next load", 6'd5, cw(2'd0, 6'd5), 1'b1);
    skip = 1'b1; opcode = 5'd6;
    @(negedge clk); chk("R8 skip at boundary", 6'd63, 8'h00, 1'b0);
    skip = 1'b0;
    @(negedge clk); chk("R8 single drop", 6'd6, cw(2'd0, 6'd6), 1'b1);
  endtask

  task automatic t_irq();
    irq = 1'b1; opcode = 5'd2;
    @(negedge clk); chk("R9 enter", 6'd48, cw(2'd3, 6'd48), 1'b0);
    irq = 1'b0;
    @(negedge clk); chk("R9 second", 6'd49, cw(2'd3, 6'd49), 1'b0);
    @(negedge clk); chk("R9 resume", 6'd2, cw(2'd0, 6'd2), 1'b1);
  endtask

  task automatic t_priority();
    stall = 1'b1; irq = 1'b1; skip = 1'b1; opcode = 5'd4;
    @(negedge clk); chk("R10 stall wins", 6'd63, 8'h00, 1'b0);
    stall = 1'b0; skip = 1'b0;
    @(negedge clk); chk("R10 irq over skip", 6'd48, cw(2'd3, 6'd48), 1'b0);
    irq = 1'b0;
    @(negedge clk); chk("R10 routine", 6'd49, cw(2'd3, 6'd49), 1'b0);
    @(negedge clk); chk("R10 skip after irq", 6'd63, 8'h00, 1'b0);
    @(negedge clk); chk("R10 opcode last", 6'd4, cw(2'd0, 6'd4), 1'b1);
  endtask

  initial begin
    t_reset();
    t_single();
    t_two_step();
    t_mem();
    t_branch();
    t_skip();
    t_irq();
    t_priority();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule